// File: doc/BRIEF.md
# Pipelined Tag Memory with Built-in Comparator

This block is a synchronous single-port word memory with an equality comparator on its read path, meant to hold cache tags. Every command (address, select pair, write and compare requests) is captured at a rising clock edge before it acts. A single input word register serves both as the write data and as the compare reference. It is reloaded only on edges where its load strobe is high. Otherwise it keeps its last value.

A read places the addressed word in an output register, so it appears one clock after the command was captured. A compare is a read whose data stays off the output. The stored word is tested against the input word register, and the equality flag is registered the same way. The data gate and the match gate are combinational. Either one, when low, drives its output to zero at once. The address width can be set anywhere from 1 to 16 bits; 16 gives 65,536 words. The data width defaults to 18 bits.

Top module: `tag_cmp_ram`

## Requirements
- R1: After a synchronous reset and before any command takes effect, `rvalid_o`, `match_o` and `rdata_o` are all zero. Reset does not clear the stored words.
- R2: A read is captured at edge E with `sel_n_i`=0, `sel_i`=1, `wr_i`=0 and `cmp_i`=0. After edge E+1, `rdata_o` holds the stored word and `rvalid_o`=1, provided `oe_i`=1.
- R3: A write captured at edge E stores the input word register into the array at edge E+1. A write never raises `rvalid_o`. A read captured at edge E+1 returns the new word. When `wr_i` and `cmp_i` are both high, the command is a write.
- R4: The input word register loads `wdata_i` on any edge where `load_i`=1, whether or not the block is selected, and holds its value otherwise. Writes and compares use the held value.
- R5: A compare is captured at edge E with select active, `wr_i`=0 and `cmp_i`=1. After edge E+1, `match_o`=1 if the addressed word equals the input word register and 0 otherwise. `rvalid_o` stays 0.
- R6: A command with `sel_n_i`=1 or `sel_i`=0 neither reads nor writes. It leaves `rvalid_o`=0 and `match_o`=0 after the following edge.
- R7: With `oe_i`=0, `rdata_o`=0 and `rvalid_o`=0 in the same instant, whatever the registered state. Raising `oe_i` again restores the held result without a clock edge.
- R8: With `moe_i`=0, `match_o`=0 in the same instant. Raising `moe_i` restores the registered flag without a clock edge.
- R9: A compare captured on the edge just after a write to the same address sees the written word. This holds even when that compare edge also reloads the input word register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address, captured at the edge |
| sel_n_i | input | 1 | Select, active low; both selects must be active |
| sel_i | input | 1 | Select, active high |
| wr_i | input | 1 | Write request, captured at the edge |
| cmp_i | input | 1 | Compare request, captured at the edge |
| load_i | input | 1 | Load strobe for the input word register |
| wdata_i | input | DATA_W | Write data or compare reference |
| oe_i | input | 1 | Combinational gate for read data |
| moe_i | input | 1 | Combinational gate for the match flag |
| rdata_o | output | DATA_W | Registered read data, zero when gated or invalid |
| rvalid_o | output | 1 | Read data valid (stands in for the pad drive) |
| match_o | output | 1 | Registered compare result, zero when gated |

## Verification
A write to the array and a compare of the same address can occur together. The write commits on the same edge that captures the compare, and that edge may also reload the input word register that the write is taking its data from. The bench provokes this with a write followed straight away by a compare that loads the same word. A match of 1 proves the compare saw the new stored word. A correct stored value proves the write used the register contents from before the reload. A later read-back checks the stored value independently.

// File: rtl/tag_cmp_pkg.sv
package tag_cmp_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2,
      CMD_CMP   = 2'd3
   } cmd_e;
endpackage

// File: rtl/tag_cmp_in_stage.sv
module tag_cmp_in_stage
   import tag_cmp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              sel_n_i,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic              cmp_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] wdata_i,
   output cmd_e              cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] word_q
);
   logic picked;
   cmd_e cmd_d;

   assign picked = !sel_n_i && sel_i;

   always_comb begin
      if (!picked)    cmd_d = CMD_IDLE;
      else if (wr_i)  cmd_d = CMD_WRITE;
      else if (cmp_i) cmd_d = CMD_CMP;
      else            cmd_d = CMD_READ;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q  <= CMD_IDLE;
         addr_q <= '0;
         word_q <= '0;
      end else begin
         cmd_q  <= cmd_d;
         addr_q <= addr_i;
         if (load_i) word_q <= wdata_i;
      end
   end

   AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(load_i)) |-> $stable(word_q)); // R4
endmodule

// File: rtl/tag_cmp_array.sv
module tag_cmp_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wen,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wen) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      wen |=> (cells[$past(waddr)] == $past(wdata))); // R3
endmodule

// File: rtl/tag_cmp_out_stage.sv
module tag_cmp_out_stage
   import tag_cmp_pkg::*;
#(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  cmd_e              cmd_q,
   input  logic [DATA_W-1:0] stored,
   input  logic [DATA_W-1:0] ref_word,
   input  logic              oe_i,
   input  logic              moe_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic              match_o
);
   logic [DATA_W-1:0] bit_eq;
   logic              same;
   logic [DATA_W-1:0] data_r;
   logic              vld_r;
   logic              hit_r;

   for (genvar b = 0; b < DATA_W; b++) begin : g_eq
      assign bit_eq[b] = stored[b] ~^ ref_word[b];
   end
   assign same = &bit_eq;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_r <= '0;
         vld_r  <= 1'b0;
         hit_r  <= 1'b0;
      end else begin
         vld_r <= (cmd_q == CMD_READ);
         hit_r <= (cmd_q == CMD_CMP) && same;
         if (cmd_q == CMD_READ) data_r <= stored;
      end
   end

   assign rvalid_o = oe_i && vld_r;
   assign rdata_o  = rvalid_o ? data_r : '0;
   assign match_o  = moe_i && hit_r;

   AST_DATA_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      (rdata_o != '0) |-> rvalid_o); // R7
endmodule

// File: rtl/tag_cmp_ram.sv
module tag_cmp_ram
   import tag_cmp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              sel_n_i,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic              cmp_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              oe_i,
   input  logic              moe_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic              match_o
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("tag_cmp_ram: ADDR_W must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("tag_cmp_ram: DATA_W must be positive");
   end

   cmd_e              cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] stored;

   tag_cmp_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
      .clk(clk), .rst(rst), .addr_i(addr_i), .sel_n_i(sel_n_i), .sel_i(sel_i),
      .wr_i(wr_i), .cmp_i(cmp_i), .load_i(load_i), .wdata_i(wdata_i),
      .cmd_q(cmd_q), .addr_q(addr_q), .word_q(word_q)
   );

   tag_cmp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .rst(rst), .wen(cmd_q == CMD_WRITE), .waddr(addr_q),
      .wdata(word_q), .raddr(addr_q), .rdata(stored)
   );

   tag_cmp_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .cmd_q(cmd_q), .stored(stored), .ref_word(word_q),
      .oe_i(oe_i), .moe_i(moe_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
      .match_o(match_o)
   );

   AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
      rvalid_o |-> $past(!sel_n_i && sel_i && !wr_i && !cmp_i, 2)); // R2
   AST_MATCH_FROM_CMP: assert property (@(posedge clk) disable iff (rst)
      match_o |-> $past(!sel_n_i && sel_i && !wr_i && cmp_i, 2)); // R5
   AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(sel_n_i || !sel_i, 2) |-> (!rvalid_o && !match_o)); // R6
endmodule

// File: tb/sim_tag_cmp_ram.sv
module sim_tag_cmp_ram;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 18;

   typedef struct {
      logic          vld;
      logic [DW-1:0] data;
      logic          hit;
      int            due;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr_i = '0;
   logic          sel_n_i = 1'b1;
   logic          sel_i = 1'b0;
   logic          wr_i = 1'b0;
   logic          cmp_i = 1'b0;
   logic          load_i = 1'b0;
   logic [DW-1:0] wdata_i = '0;
   logic          oe_i = 1'b1;
   logic          moe_i = 1'b1;
   logic [DW-1:0] rdata_o;
   logic          rvalid_o;
   logic          match_o;

   int            n_chk = 0;
   int            n_err = 0;
   int            cyc = 0;
   exp_t          pend[$];
   logic [DW-1:0] model [int];
   logic [DW-1:0] word_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tag_cmp_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst(rst), .addr_i(addr_i), .sel_n_i(sel_n_i), .sel_i(sel_i),
      .wr_i(wr_i), .cmp_i(cmp_i), .load_i(load_i), .wdata_i(wdata_i),
      .oe_i(oe_i), .moe_i(moe_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
      .match_o(match_o)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // driver: apply one command at a falling edge and record its expected outcome
   task automatic issue(input bit sn, input bit s, input bit w, input bit c,
                        input bit ld, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
      exp_t e;
      bit picked;
      @(negedge clk);
      sel_n_i = sn; sel_i = s; wr_i = w; cmp_i = c; load_i = ld;
      addr_i = a; wdata_i = d;
      picked = !sn && s;
      if (ld) word_m = d;
      e.vld = picked && !w && !c;
      e.data = model.exists(int'(a)) ? model[int'(a)] : '0;
      e.hit = picked && !w && c && model.exists(int'(a)) && (model[int'(a)] == word_m);
      e.due = cyc + 2;
      e.tag = tag;
      if (picked && w) model[int'(a)] = word_m;
      pend.push_back(e);
   endtask

   task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, a, d, tag);
   endtask
   task automatic do_rd(input logic [AW-1:0] a, input string tag);
      issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, '0, tag);
   endtask
   task automatic do_idle();
      issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "idle");
   endtask

   // monitor: compare outputs against queued expectations just after each edge
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         while (pend.size() > 0 && pend[0].due == cyc) begin
            exp_t e;
            logic ok;
            e = pend.pop_front();
            ok = (rvalid_o == e.vld) && (match_o == e.hit) &&
                 (rdata_o == (e.vld ? e.data : '0));
            check(ok, e.tag, {rvalid_o, match_o, 12'h0, rdata_o},
                  {e.vld, e.hit, 12'h0, (e.vld ? e.data : 18'h0)});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check(!rvalid_o && !match_o && rdata_o == '0, "R1 reset",
            {rvalid_o, match_o, 12'h0, rdata_o}, 32'h0);

      // R2 R3: write then read, back to back and later
      do_wr(8'd5, 18'h2ABCD, "R3 write quiet");
      do_rd(8'd5, "R3 read after write");
      do_wr(8'd9, 18'h15555, "R3 write quiet");
      do_idle();
      do_rd(8'd9, "R2 read latency");
      do_wr(8'd0, 18'h3FFFF, "R3 low addr");
      do_wr(8'd255, 18'h00001, "R3 high addr");
      do_rd(8'd0, "R2 low addr");
      do_rd(8'd255, "R2 high addr");
      // R3: write wins over compare when both requested
      issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40, 18'h0F0F0, "R3 write priority");
      do_rd(8'd40, "R3 write priority readback");

      // R5: compare hit and miss
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 18'h2ABCD, "R5 compare hit");
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 18'h00001, "R5 compare miss");

      // R4: held word register drives write and compare
      issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd20, 18'h3C3C3, "R4 write held word");
      do_rd(8'd20, "R4 readback held word");
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd20, 18'h12345, "R4 compare held word");
      // R4: load while deselected still updates the register
      issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 18'h2ABCD, "R4 unselected load");
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd5, 18'h0, "R4 compare after unselected load");

      // R6: deselected write and compare do nothing
      issue(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd9, 18'h00000, "R6 write sel_n high");
      issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd9, 18'h00000, "R6 write sel low");
      do_rd(8'd9, "R6 location untouched");
      issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5, 18'h2ABCD, "R6 compare unselected");
      issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5, 18'h0, "R6 read unselected");

      // R9: compare right after write, same edge reloads the word register
      do_wr(8'd30, 18'h3FFFF, "R9 write");
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd30, 18'h3FFFF, "R9 compare after write");
      do_wr(8'd31, 18'h11111, "R9 write");
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd31, 18'h22222, "R9 compare reload differs");
      do_rd(8'd31, "R9 stored old register value");

      // R2: sweep of addresses
      for (int i = 0; i < 16; i++) do_wr(AW'(i * 13 + 2), DW'(i * 9001 + 7), "R3 sweep write");
      for (int i = 0; i < 16; i++) do_rd(AW'(i * 13 + 2), "R2 sweep read");
      do_idle();

      // R7: data gate acts without a clock edge
      do_rd(8'd5, "R7 setup read");
      @(posedge clk); @(posedge clk); #3;
      oe_i = 1'b0; #1;
      check(rdata_o == '0 && !rvalid_o, "R7 gate off", {rvalid_o, 13'h0, rdata_o}, 32'h0);
      oe_i = 1'b1; #1;
      check(rdata_o == 18'h2ABCD && rvalid_o, "R7 gate on",
            {rvalid_o, 13'h0, rdata_o}, {1'b1, 13'h0, 18'h2ABCD});

      // R8: match gate acts without a clock edge
      word_m = 18'h2ABCD;
      issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 18'h2ABCD, "R8 setup compare");
      @(posedge clk); @(posedge clk); #3;
      moe_i = 1'b0; #1;
      check(!match_o, "R8 gate off", {31'h0, match_o}, 32'h0);
      moe_i = 1'b1; #1;
      check(match_o, "R8 gate on", {31'h0, match_o}, 32'h1);

      do_idle();
      do_idle();
      repeat (4) @(posedge clk);
      check(pend.size() == 0, "all expectations consumed", pend.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule